// File: doc/BRIEF.md
# First-Word-Fall-Through FIFO Cascade

This block builds a deep first-in first-out buffer out of several small first-word-fall-through stages. The stages sit in series: the data output of each stage feeds the data input of the next. Two active-low flags link each pair of neighbours. The first is "output ready", which is low while a stage holds a word. The second is "input ready", which is low while a stage has room. A word moves on whenever the upstream stage has one and the downstream stage has space. So a word written at the head moves down the chain by itself until it reaches the tail output, and no read request is needed for that.

A producer writes at the head, gated by the head's input-ready flag. A consumer reads at the tail, gated by the tail's output-ready flag. Because the mode is first-word-fall-through, the word at the tail is already on `rd_data` while `out_rdy_n` is low. A read only removes it. The transfer clock runs freely, and both ports are sampled on its rising edge.

Each stage is driven by a small occupancy state machine with three states: ST_EMPTY, ST_PARTIAL and ST_FULL. Its transitions are:
- fill: ST_EMPTY to ST_PARTIAL, on a push.
- top-up: ST_PARTIAL to ST_FULL, on a push without a pop when one slot is left.
- drain: ST_PARTIAL to ST_EMPTY, on a pop without a push when one word is left.
- release: ST_FULL to ST_PARTIAL, on a pop.

In every other case the stage keeps its state. A stage must be at least two words deep.

Top module: `fwft_cascade`

## Requirements
- R1: After reset is released, `in_rdy_n` is 0 (room) and `out_rdy_n` is 1 (no word).
- R2: A write is taken on a rising edge only when `wr_en` is 1 and `in_rdy_n` is 0. A write attempted while `in_rdy_n` is 1, or data presented while `wr_en` is 0, leaves the contents unchanged.
- R3: A word written into an empty cascade of N stages, with no read, makes `out_rdy_n` go low and appears on `rd_data` right after the (N-1)th rising edge that follows the edge that wrote it. It is not visible before that edge.
- R4: Inside the chain, a word moves from one stage to the next on an edge exactly when the upstream output-ready is low and the downstream input-ready is low. Output-ready low means "holds a word" and input-ready low means "has room".
- R5: With no reads, exactly N × D writes are accepted before `in_rdy_n` settles high. D is the depth of one stage.
- R6: Words leave the tail in the order they were accepted at the head, with none lost and none duplicated.
- R7: While `out_rdy_n` is low and `rd_en` is 0, `rd_data` and `out_rdy_n` do not change.
- R8: `rd_en` asserted while `out_rdy_n` is 1 is ignored. Later words still come out intact and in order.
- R9: Once primed, with `wr_en` and `rd_en` both held at 1, one word is written and one word is read on every clock, and `in_rdy_n` stays 0.
- R10: `in_rdy_n` reflects only the head stage. After one read from a full cascade, it stays 1 for N-2 more edges and goes 0 right after the (N-1)th edge following the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running transfer clock; both ports are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset; empties every stage |
| wr_en | input | 1 | Write request at the head |
| wr_data | input | WIDTH | Word to write |
| in_rdy_n | output | 1 | Active-low: head stage has room |
| rd_en | input | 1 | Read request at the tail |
| rd_data | output | WIDTH | Word at the tail (valid while out_rdy_n is 0) |
| out_rdy_n | output | 1 | Active-low: tail stage holds a word |

## Verification
The bench times the ripple of a lone word through an empty chain, edge by edge. A design with an extra or a missing register per stage shows the word early or late. It fills the chain with reads held off, then counts accepted writes and times how room travels back to the head after one read. An off-by-one full test, or a head flag that looks at the whole chain, shows up as a wrong capacity or a wrong return time. Reads are attempted on an empty chain and writes on a full one; if the pointers move in either case, the scoreboard sees a phantom or a lost word. Runs with both ends always enabled and with random enables would expose a stall bubble or reordering as a missing read or a data mismatch.

// File: rtl/fwft_pkg.sv
package fwft_pkg;

    // Occupancy state of one cascade stage
    typedef enum logic [1:0] {
        ST_EMPTY   = 2'd0,
        ST_PARTIAL = 2'd1,
        ST_FULL    = 2'd2
    } stage_state_e;

endpackage

// File: rtl/fwft_ram.sv
// Storage array of one stage: one synchronous write port, one asynchronous read port.
module fwft_ram #(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4,
    parameter int AW    = 2
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fwft_stage.sv
// One first-word-fall-through stage: the oldest word is always on out_data.
module fwft_stage
    import fwft_pkg::*;
#(
    parameter int WIDTH = 18,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_req,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic             in_rdy_n,
    output logic             out_rdy_n,
    output logic [WIDTH-1:0] out_data
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] ONE_LEFT  = CW'(DEPTH - 1);

    stage_state_e     state_q, state_d;
    logic [CW-1:0]    count_q, count_d;
    logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
    logic             do_push, do_pop;

    // Accepted operations: push needs room, pop needs a word
    assign do_push = push_req && (state_q != ST_FULL);
    assign do_pop  = pop_req  && (state_q != ST_EMPTY);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: begin
                if (do_push) state_d = ST_PARTIAL;              // fill
            end
            ST_PARTIAL: begin
                if (do_push && !do_pop && count_q == ONE_LEFT)
                    state_d = ST_FULL;                          // top-up
                else if (do_pop && !do_push && count_q == CW'(1))
                    state_d = ST_EMPTY;                         // drain
            end
            ST_FULL: begin
                if (do_pop) state_d = ST_PARTIAL;               // release
            end
            default: state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        count_d = count_q;
        if (do_push && !do_pop)      count_d = count_q + CW'(1);
        else if (do_pop && !do_push) count_d = count_q - CW'(1);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_EMPTY;
            count_q  <= '0;
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
            if (do_push) wr_ptr_q <= (wr_ptr_q == LAST_ADDR) ? '0 : wr_ptr_q + AW'(1);
            if (do_pop)  rd_ptr_q <= (rd_ptr_q == LAST_ADDR) ? '0 : rd_ptr_q + AW'(1);
        end
    end

    // Outputs decoded from state
    always_comb begin
        in_rdy_n  = 1'b0;
        out_rdy_n = 1'b0;
        unique case (state_q)
            ST_EMPTY:   out_rdy_n = 1'b1;
            ST_PARTIAL: ;
            ST_FULL:    in_rdy_n  = 1'b1;
            default:    out_rdy_n = 1'b1;
        endcase
    end

    fwft_ram #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH),
        .AW    (AW)
    ) i_ram (
        .clk   (clk),
        .we    (do_push),
        .waddr (wr_ptr_q),
        .wdata (push_data),
        .raddr (rd_ptr_q),
        .rdata (out_data)
    );

    // Occupancy never exceeds the stage depth
    a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= CW'(DEPTH));

    // A push into an empty stage is visible after one edge
    a_r4_fill_shows_word: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy_n && push_req) |=> !out_rdy_n);

    // The word on offer holds until it is popped
    a_r7_hold_word: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_rdy_n && !pop_req) |=> (!out_rdy_n && $stable(out_data)));

    // A full stage stays full until popped, whatever the push request
    a_r2_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (in_rdy_n && !pop_req) |=> in_rdy_n);

endmodule

// File: rtl/fwft_cascade.sv
// Series chain of first-word-fall-through stages; words ripple head to tail.
module fwft_cascade #(
    parameter int WIDTH  = 18,
    parameter int DEPTH  = 4,
    parameter int STAGES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             in_rdy_n,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             out_rdy_n
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0]  lnk_data [STAGES];
    logic [STAGES-1:0] lnk_or_n;
    logic [STAGES-1:0] lnk_ir_n;
    logic [STAGES-1:0] lnk_push;
    logic [STAGES-1:0] lnk_pop;
    logic [WIDTH-1:0]  lnk_din  [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            assign lnk_push[k] = wr_en;
            assign lnk_din[k]  = wr_data;
        end else begin : g_inner
            // upstream word present -> offer it downstream
            assign lnk_push[k] = !lnk_or_n[k-1];
            assign lnk_din[k]  = lnk_data[k-1];
        end

        if (k == LAST) begin : g_tail
            assign lnk_pop[k] = rd_en;
        end else begin : g_mid
            // downstream has room -> release the word
            assign lnk_pop[k] = !lnk_ir_n[k+1];
        end

        fwft_stage #(
            .WIDTH (WIDTH),
            .DEPTH (DEPTH)
        ) i_stage (
            .clk       (clk),
            .rst_n     (rst_n),
            .push_req  (lnk_push[k]),
            .push_data (lnk_din[k]),
            .pop_req   (lnk_pop[k]),
            .in_rdy_n  (lnk_ir_n[k]),
            .out_rdy_n (lnk_or_n[k]),
            .out_data  (lnk_data[k])
        );
    end

    assign in_rdy_n  = lnk_ir_n[0];
    assign out_rdy_n = lnk_or_n[LAST];
    assign rd_data   = lnk_data[LAST];

    // A read on an empty tail cannot make a word appear unless one was rippling in
    a_r8_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        (out_rdy_n && rd_en && (STAGES == 1 ? !wr_en : lnk_or_n[(LAST > 0) ? LAST-1 : 0]))
        |=> out_rdy_n);

    // Head with room and no write cannot become full
    a_r10_head_room: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_rdy_n && !wr_en) |=> !in_rdy_n);

endmodule

// File: tb/test_fwft_cascade.sv
module test_fwft_cascade;

    localparam int NS  = 4;
    localparam int SD  = 4;
    localparam int DW  = 18;
    localparam int CAP = NS * SD;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en;
    logic [DW-1:0] wr_data;
    logic          rd_en;
    logic          in_rdy_n;
    logic          out_rdy_n;
    logic [DW-1:0] rd_data;

    int n_checks = 0;
    int n_fail   = 0;
    int n_reads  = 0;
    int n_writes = 0;
    bit done     = 1'b0;
    logic [DW-1:0] exp_q [$];

    always #5 clk = ~clk;

    fwft_cascade #(.WIDTH(DW), .DEPTH(SD), .STAGES(NS)) i_fwft_cascade (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .in_rdy_n  (in_rdy_n),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .out_rdy_n (out_rdy_n)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    // advance to the falling edge after the next rising edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // driver: set inputs at a falling edge, record writes that will be accepted
    task automatic put(input bit we, input logic [DW-1:0] d, input bit re);
        wr_en   = we;
        wr_data = d;
        rd_en   = re;
        if (we && !in_rdy_n) begin
            exp_q.push_back(d);
            n_writes++;
        end
    endtask

    task automatic drain(input string tag);
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) begin
            put(1'b0, '0, 1'b1);
            step();
        end
        put(1'b0, '0, 1'b0);
        step();
        chk(exp_q.size() == 0, tag, exp_q.size(), 0);
        chk(out_rdy_n == 1'b1, tag, out_rdy_n, 1);
    endtask

    // monitor: compare each accepted read with the scoreboard head
    always @(posedge clk) begin
        if (rst_n && rd_en && !out_rdy_n) begin
            n_reads++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R6 phantom word", rd_data, 0);
            end else begin
                chk(rd_data == exp_q[0], "R6 order/data", rd_data, exp_q[0]);
                void'(exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        int acc;
        int r0, w0, busy;
        rst_n = 1'b0;
        wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step();

        // R1 reset state
        chk(in_rdy_n == 1'b0, "R1 in_rdy_n after reset", in_rdy_n, 0);
        chk(out_rdy_n == 1'b1, "R1 out_rdy_n after reset", out_rdy_n, 1);

        // R3 ripple latency of a lone word
        put(1'b1, 18'h1A5, 1'b0);
        step();
        put(1'b0, '0, 1'b0);
        for (int k = 0; k < NS - 1; k++) begin
            chk(out_rdy_n == 1'b1, "R3 word visible too early", out_rdy_n, 1);
            step();
        end
        chk(out_rdy_n == 1'b0, "R3 word not at tail on time", out_rdy_n, 0);
        chk(rd_data == 18'h1A5, "R3 tail data", rd_data, 18'h1A5);

        // R7 word held while not read
        for (int k = 0; k < 5; k++) begin
            step();
            chk(!out_rdy_n && rd_data == 18'h1A5, "R7 tail word held", rd_data, 18'h1A5);
        end
        put(1'b0, '0, 1'b1);
        step();
        put(1'b0, '0, 1'b0);
        chk(exp_q.size() == 0, "R6 single word read", exp_q.size(), 0);

        // R8 reads on an empty cascade are ignored
        put(1'b0, '0, 1'b1);
        repeat (4) step();
        chk(out_rdy_n == 1'b1, "R8 empty read ignored", out_rdy_n, 1);
        chk(in_rdy_n == 1'b0, "R8 room kept", in_rdy_n, 0);
        put(1'b0, '0, 1'b0);
        put(1'b1, 18'h00B01, 1'b0); step();
        put(1'b1, 18'h00B02, 1'b0); step();
        put(1'b0, 18'h3FFFF, 1'b0); step();   // R2: data without wr_en ignored
        repeat (NS + 2) step();
        drain("R8 words after empty reads");

        // R5 / R4 capacity equals the sum of stage depths
        acc = 0;
        for (int k = 0; k < CAP * NS + 20; k++) begin
            if (!in_rdy_n) acc++;
            put(1'b1, DW'(18'h20000 + k), 1'b0);   // R2: writes while full are ignored
            step();
        end
        put(1'b0, '0, 1'b0);
        chk(acc == CAP, "R5 R4 accepted writes", acc, CAP);
        chk(in_rdy_n == 1'b1, "R5 head full", in_rdy_n, 1);
        chk(out_rdy_n == 1'b0 && rd_data == DW'(18'h20000), "R2 tail holds first fill word",
            rd_data, 18'h20000);

        // R10 room travels back to the head
        put(1'b0, '0, 1'b1);
        step();
        put(1'b0, '0, 1'b0);
        for (int k = 0; k < NS - 1; k++) begin
            chk(in_rdy_n == 1'b1, "R10 head room too early", in_rdy_n, 1);
            step();
        end
        chk(in_rdy_n == 1'b0, "R10 head room on time", in_rdy_n, 0);
        drain("R6 R2 drain after fill");

        // R9 sustained one word per clock
        for (int k = 0; k < NS + 2; k++) begin
            put(1'b1, DW'(18'h10000 + k), 1'b1);
            step();
        end
        r0 = n_reads; w0 = n_writes; busy = 0;
        for (int k = 0; k < 40; k++) begin
            if (in_rdy_n) busy++;
            put(1'b1, DW'(18'h11000 + k), 1'b1);
            step();
        end
        chk(n_reads - r0 == 40, "R9 reads per clock", n_reads - r0, 40);
        chk(n_writes - w0 == 40, "R9 writes per clock", n_writes - w0, 40);
        chk(busy == 0, "R9 head never full", busy, 0);
        drain("R9 drain");

        // R6 random enables at both ends
        for (int k = 0; k < 3000; k++) begin
            bit we, re;
            if (k < 1500) begin
                we = ($urandom % 4) != 0;
                re = ($urandom % 3) == 0;
            end else begin
                we = ($urandom % 3) == 0;
                re = ($urandom % 4) != 0;
            end
            put(we, DW'($urandom), re);
            step();
        end
        drain("R6 random traffic lossless");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule